// File: doc/BRIEF.md
# I2C Target Register-Pointer Engine

This block is the serial front end of a small byte-wide register space. It listens on a two-wire I2C bus as a target with one fixed 7-bit address. It holds an internal pointer that selects one of the register locations. In a write frame, the first byte after the address loads the pointer. The engine then takes at most one data byte, so all register access happens at the pointer. A read frame returns bytes from the pointer. The pointer moves forward each time a byte is acknowledged, and it wraps from the top location back to zero.

The register storage is outside the block. The engine presents the pointer on `reg_addr` and expects the byte at that address to come back on `reg_rdata` in the same cycle. A write is issued as a single-cycle strobe. SCL is only ever observed. The target uses SDA only through an open-drain enable: when the enable is high, the line is pulled low.

A guard counter watches for a bus that stays low for too long. When that happens, the engine lets go of SDA and returns to idle. If a line is still low a short time after this release, the engine raises a sleep request.

Top module: `i2c_regptr_target`

## Requirements
- R1: A first byte of 0xAA (address 1010101b plus write bit 0) or 0xAB (read bit 1) is acknowledged. Any other address byte is NACKed, and the rest of that frame is ignored: SDA is never driven and the pointer is unchanged.
- R2: In a write frame, a command byte of 0x00 to 0x7F is acknowledged and loads the pointer. A command byte of 0x80 or above is NACKed and leaves the pointer unchanged.
- R3: The first data byte of a write frame that targets a writable location is acknowledged. It causes one `reg_wr` pulse, during which `reg_addr` equals the pointer and `reg_wdata` equals the byte. The pointer then advances by one.
- R4: A data byte aimed at a read-only location is NACKed, causes no write and leaves the pointer unchanged. With the default mask, locations 0x40 to 0x7F are read-only and 0x00 to 0x3F are writable.
- R5: Every data byte after the first in one write frame is NACKed and produces no write.
- R6: A read frame that starts directly with 0xAB (quick read) returns the byte at the current pointer, most significant bit first.
- R7: A write of a command byte, followed by a repeated START, 0xAB and one byte read, returns the byte at the commanded location.
- R8: During a read, each byte that the controller ACKs advances the pointer, and the pointer goes from 0x7F to 0x00. A byte that the controller NACKs does not advance the pointer and ends the frame.
- R9: A STOP or START seen part-way through a byte abandons that byte. No write happens, SDA is released and the pointer is kept.
- R10: SDA begins being pulled low only while the synchronised SCL is low.
- R11: If either line stays low for TIMEOUT clocks, SDA is released within one further cycle and the engine returns to idle. The count restarts whenever both lines are high.
- R12: `sleep_req` is raised when a line is still low SETTLE clocks after the release. It drops as soon as both lines are high, and it is never high without a release.
- R13: After reset, SDA is released, `sleep_req` and `reg_wr` are low and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the bus is oversampled with it |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| sleep_req | output | 1 | Request for low-power sleep after a stuck bus |
| reg_addr | output | 7 | Current pointer, used for reads and for writes |
| reg_rdata | input | 8 | Byte stored at `reg_addr` |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 8 | Byte to write at `reg_addr` |

## Verification
Write frames are run from a table of command and data pairs that hits both sides of the read-only boundary and both ends of the space. Each write is read back with a repeated-start read, which separates accepted bytes from refused ones. Directed frames then cover the remaining access paths: a foreign address, an oversized command, surplus data bytes, a quick read and an incremental read across 0x7F. Together they separate correct pointer loading, advancing and wrapping from off-by-one behaviour. A frame cut short by STOP, and an SCL held low during an acknowledge, show that abort and watchdog release leave the pointer and storage untouched and that the sleep request follows the release.

// File: rtl/i2c_rp_pkg.sv
// Package: shared types for the I2C register-pointer target.
// Assumes: used by every module of the block; holds no logic.
package i2c_rp_pkg;

    // Engine state within one frame
    typedef enum logic [2:0] {
        ST_IDLE,     // bus free or frame done
        ST_RX,       // shifting in a byte from the controller
        ST_ACKWAIT,  // byte complete, waiting for SCL low to drive ACK
        ST_ACK,      // ACK/NACK slot in progress
        ST_TX,       // shifting out a read byte
        ST_MACK,     // controller ACK/NACK slot after a read byte
        ST_WAIT      // ignoring the bus until START or STOP
    } rp_state_t;

    // What the next received byte means
    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_DATA
    } rp_phase_t;

    // Synchronised bus levels and detected events
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } rp_bus_t;

endpackage

// File: rtl/i2c_rp_sync.sv
// Module: synchronises SCL/SDA and detects START, STOP and SCL edges.
// Assumes: SYNC_STAGES >= 2; the idle bus is high, so all flops reset to 1.
module i2c_rp_sync
    import i2c_rp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output rp_bus_t bus
);

    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_ff[SYNC_STAGES-1];
    assign sda_s = sda_ff[SYNC_STAGES-1];

    // Synchroniser chains plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    // Event decode: SDA moving while SCL stays high is START or STOP
    always_comb begin
        bus.scl   = scl_s;
        bus.sda   = sda_s;
        bus.rise  = scl_s & ~scl_q;
        bus.fall  = ~scl_s & scl_q;
        bus.start = scl_s & scl_q & sda_q & ~sda_s;
        bus.stop  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_rp_watchdog.sv
// Module: stuck-bus guard. Counts clocks while either line is low.
// Assumes: lines already synchronised; TIMEOUT >= 1, SETTLE >= 1.
module i2c_rp_watchdog #(
    parameter int TIMEOUT = 100_000_000,
    parameter int SETTLE  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic release_o,
    output logic sleep_o
);

    localparam int LIMIT = TIMEOUT + SETTLE;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TO_C  = CW'(TIMEOUT);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

    logic [CW-1:0] cnt;
    logic          idle_hi;

    assign idle_hi = scl_s & sda_s;

    // Saturating low-time counter, cleared by a free bus
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (idle_hi) cnt <= '0;
        else if (cnt != LIM_C) cnt <= cnt + 1'b1;
    end

    // Registered release and sleep flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            release_o <= 1'b0;
            sleep_o   <= 1'b0;
        end else begin
            release_o <= ~idle_hi & (cnt >= TO_C);
            sleep_o   <= ~idle_hi & (cnt == LIM_C);
        end
    end

endmodule

// File: rtl/i2c_rp_engine.sv
// Module: byte shifter, ACK/NACK logic and pointer for the target.
// Assumes: bus events come from i2c_rp_sync; reg_rdata is valid in the
// same cycle as reg_addr; REG_DEPTH is a power of two no larger than 256.
module i2c_rp_engine
    import i2c_rp_pkg::*;
#(
    parameter logic [6:0]           DEV_ADDR  = 7'h55,
    parameter int                   REG_DEPTH = 128,
    parameter logic [REG_DEPTH-1:0] RO_MASK   = {{(REG_DEPTH/2){1'b1}}, {(REG_DEPTH/2){1'b0}}},
    localparam int                  PTR_W     = $clog2(REG_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic             ev_rise,
    input  logic             ev_fall,
    input  logic             sda_s,
    input  logic             flush,
    input  logic [7:0]       reg_rdata,
    output logic             sda_oe,
    output logic [PTR_W-1:0] ptr,
    output logic             reg_wr,
    output logic [7:0]       reg_wdata
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(REG_DEPTH - 1);

    rp_state_t        state;
    rp_phase_t        phase;
    logic [3:0]       bit_cnt;
    logic [6:0]       shreg;
    logic [7:0]       tx_sh;
    logic             ack_q;
    logic             is_read;
    logic             first_data;
    logic [7:0]       rx_byte;
    logic             cmd_ok;
    logic [PTR_W-1:0] ptr_next;

    assign rx_byte  = {shreg, sda_s};
    assign cmd_ok   = ({1'b0, rx_byte} < 9'(REG_DEPTH));
    assign ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;

    // Frame sequencer: receive, acknowledge, transmit and pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            phase      <= PH_ADDR;
            bit_cnt    <= '0;
            shreg      <= '0;
            tx_sh      <= '0;
            ack_q      <= 1'b0;
            is_read    <= 1'b0;
            first_data <= 1'b0;
            sda_oe     <= 1'b0;
            ptr        <= '0;
            reg_wr     <= 1'b0;
            reg_wdata  <= '0;
        end else begin
            reg_wr <= 1'b0;
            if (reg_wr) ptr <= ptr_next;
            if (flush) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev_start) begin
                state   <= ST_RX;
                phase   <= PH_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (ev_stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: if (ev_rise) begin
                        shreg   <= rx_byte[6:0];
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == 4'd7) begin
                            state <= ST_ACKWAIT;
                            unique case (phase)
                                PH_ADDR: begin
                                    ack_q   <= (rx_byte[7:1] == DEV_ADDR);
                                    is_read <= rx_byte[0];
                                end
                                PH_CMD: begin
                                    ack_q      <= cmd_ok;
                                    first_data <= cmd_ok;
                                    if (cmd_ok) ptr <= rx_byte[PTR_W-1:0];
                                end
                                default: begin
                                    first_data <= 1'b0;
                                    if (first_data && !RO_MASK[ptr]) begin
                                        ack_q     <= 1'b1;
                                        reg_wr    <= 1'b1;
                                        reg_wdata <= rx_byte;
                                    end else begin
                                        ack_q <= 1'b0;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_ACKWAIT: if (ev_fall) begin
                        sda_oe <= ack_q;
                        state  <= ST_ACK;
                    end
                    ST_ACK: if (ev_fall) begin
                        bit_cnt <= '0;
                        if (!ack_q && phase != PH_DATA) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WAIT;
                        end else if (phase == PH_ADDR && is_read) begin
                            sda_oe  <= ~reg_rdata[7];
                            tx_sh   <= {reg_rdata[6:0], 1'b0};
                            bit_cnt <= 4'd1;
                            state   <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                            phase  <= (phase == PH_ADDR) ? PH_CMD : PH_DATA;
                        end
                    end
                    ST_TX: if (ev_fall) begin
                        if (bit_cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                        end else begin
                            sda_oe  <= ~tx_sh[7];
                            tx_sh   <= tx_sh << 1;
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_MACK: if (ev_rise) begin
                        ack_q <= ~sda_s;
                        if (!sda_s) ptr <= ptr_next;
                    end else if (ev_fall) begin
                        if (ack_q) begin
                            sda_oe  <= ~reg_rdata[7];
                            tx_sh   <= {reg_rdata[6:0], 1'b0};
                            bit_cnt <= 4'd1;
                            state   <= ST_TX;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regptr_target.sv
// Module: top of the I2C register-pointer target.
// Assumes: external register storage answers reg_rdata combinationally
// from reg_addr; SCL is never driven (no clock stretching).
module i2c_regptr_target #(
    parameter logic [6:0]   DEV_ADDR    = 7'h55,
    parameter int           REG_DEPTH   = 128,
    parameter logic [REG_DEPTH-1:0] RO_MASK = {{(REG_DEPTH/2){1'b1}}, {(REG_DEPTH/2){1'b0}}},
    parameter int           TIMEOUT     = 100_000_000,
    parameter int           SETTLE      = 16,
    parameter int           SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       sleep_req,
    output logic [6:0] reg_addr,
    input  logic [7:0] reg_rdata,
    output logic       reg_wr,
    output logic [7:0] reg_wdata
);

    import i2c_rp_pkg::*;

    rp_bus_t bus;
    logic    scl_s;
    logic    bus_start;
    logic    wd_release;

    assign scl_s     = bus.scl;
    assign bus_start = bus.start;

    i2c_rp_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .bus   (bus)
    );

    i2c_rp_watchdog #(.TIMEOUT(TIMEOUT), .SETTLE(SETTLE)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (bus.scl),
        .sda_s     (bus.sda),
        .release_o (wd_release),
        .sleep_o   (sleep_req)
    );

    i2c_rp_engine #(
        .DEV_ADDR  (DEV_ADDR),
        .REG_DEPTH (REG_DEPTH),
        .RO_MASK   (RO_MASK)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_start  (bus.start),
        .ev_stop   (bus.stop),
        .ev_rise   (bus.rise),
        .ev_fall   (bus.fall),
        .sda_s     (bus.sda),
        .flush     (wd_release),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .ptr       (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata)
    );

endmodule

// File: rtl/i2c_regptr_target_chk.sv
// Module: protocol checker bound to i2c_regptr_target.
// Assumes: observes internal synchronised SCL, START and watchdog release.
module i2c_regptr_target_chk #(
    parameter int                   REG_DEPTH = 128,
    parameter logic [REG_DEPTH-1:0] RO_MASK   = '0,
    localparam int                  PTR_W     = $clog2(REG_DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             bus_start,
    input logic             sda_oe,
    input logic             wd_release,
    input logic             sleep_req,
    input logic             reg_wr,
    input logic [PTR_W-1:0] reg_addr
);

    logic wr_seen;

    // Tracks whether a write already happened since the last START
    always_ff @(posedge clk) begin
        if (!rst_n)         wr_seen <= 1'b0;
        else if (bus_start) wr_seen <= 1'b0;
        else if (reg_wr)    wr_seen <= 1'b1;
    end

    // R10
    sda_drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s));

    // R11
    release_frees_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_release |=> !sda_oe);

    // R12
    sleep_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> wd_release);

    // R3
    write_advances_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));

    // R4
    write_ro_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !RO_MASK[reg_addr]);

    // R5
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !wr_seen);

endmodule

bind i2c_regptr_target i2c_regptr_target_chk #(
    .REG_DEPTH (REG_DEPTH),
    .RO_MASK   (RO_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .bus_start  (bus_start),
    .sda_oe     (sda_oe),
    .wd_release (wd_release),
    .sleep_req  (sleep_req),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr)
);

// File: tb/i2c_regptr_target_tb.sv
// Bench: drives the bus as an I2C controller and models the register space.
module i2c_regptr_target_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HB         = 8;
    localparam int TO         = 400;
    localparam int ST         = 8;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] data;
        logic       ack;
    } vec_t;

    // Write vectors: command, data, expected data ACK (0x40..0x7F read-only)
    localparam vec_t VEC [6] = '{
        '{8'h05, 8'h3C, 1'b1},
        '{8'h3F, 8'hC3, 1'b1},
        '{8'h40, 8'h11, 1'b0},
        '{8'h7F, 8'h22, 1'b0},
        '{8'h00, 8'h99, 1'b1},
        '{8'h20, 8'h00, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       sleep_req;
    logic [6:0] reg_addr;
    logic [7:0] reg_rdata;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] regs [128];
    int         total = 0;
    int         bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = regs[reg_addr];

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    // Register storage model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) regs[i] <= init_val(i);
        end else if (reg_wr) begin
            regs[reg_addr] <= reg_wdata;
        end
    end

    i2c_regptr_target #(.TIMEOUT(TO), .SETTLE(ST)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .sleep_req (sleep_req),
        .reg_addr  (reg_addr),
        .reg_rdata (reg_rdata),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_w(input logic b);
        sda_m = b; tick(HB);
        scl_m = 1'b1; tick(HB);
        scl_m = 1'b0; tick(HB/2);
    endtask

    task automatic bit_r(output logic b);
        sda_m = 1'b1; tick(HB);
        scl_m = 1'b1; tick(HB/2);
        b = sda_line; tick(HB/2);
        scl_m = 1'b0; tick(HB/2);
    endtask

    task automatic cond_start();
        sda_m = 1'b1; tick(HB);
        scl_m = 1'b1; tick(HB);
        sda_m = 1'b0; tick(HB);
        scl_m = 1'b0; tick(HB/2);
    endtask

    task automatic cond_stop();
        sda_m = 1'b0; tick(HB);
        scl_m = 1'b1; tick(HB);
        sda_m = 1'b1; tick(HB);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) bit_w(b[i]);
        bit_r(x);
        ack = ~x;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            bit_r(x);
            d[i] = x;
        end
        bit_w(~give_ack);
    endtask

    task automatic quick_rd(output logic [7:0] d);
        logic a;
        cond_start(); send_byte(8'hAB, a);
        recv_byte(1'b0, d); cond_stop();
    endtask

    task automatic rd_one(input logic [7:0] cmd, output logic [7:0] d);
        logic a;
        cond_start(); send_byte(8'hAA, a); send_byte(cmd, a);
        cond_start(); send_byte(8'hAB, a);
        recv_byte(1'b0, d); cond_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic       a, a2, a3;
        logic [7:0] d;
        logic [6:0] keep;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R13 reset state
        chk("R13 sda_oe", sda_oe, 0);
        chk("R13 sleep_req", sleep_req, 0);
        chk("R13 reg_wr", reg_wr, 0);
        chk("R13 pointer", reg_addr, 0);

        // Table of write frames, each read back (R3 R4 R7)
        for (int k = 0; k < 6; k++) begin
            cond_start();
            send_byte(8'hAA, a);
            chk("R1 write address ack", a, 1);
            send_byte(VEC[k].cmd, a);
            chk("R2 command ack", a, 1);
            send_byte(VEC[k].data, a);
            cond_stop();
            chk(VEC[k].ack ? "R3 data ack" : "R4 read-only nack", a, VEC[k].ack);
            chk(VEC[k].ack ? "R3 pointer advance" : "R4 pointer kept", reg_addr,
                VEC[k].ack ? 7'(VEC[k].cmd + 1) : 7'(VEC[k].cmd));
            rd_one(VEC[k].cmd, d);
            chk("R7 readback", d, VEC[k].ack ? VEC[k].data : init_val(VEC[k].cmd));
        end

        // R1 foreign address ignored
        keep = reg_addr;
        cond_start(); send_byte(8'hA8, a); send_byte(8'h10, a2); cond_stop();
        chk("R1 foreign address nack", a, 0);
        chk("R1 following byte ignored", a2, 0);
        chk("R1 pointer kept", reg_addr, keep);

        // R2 oversize command
        cond_start(); send_byte(8'hAA, a); send_byte(8'h85, a2); cond_stop();
        chk("R2 command above 0x7F nack", a2, 0);
        chk("R2 pointer kept", reg_addr, keep);

        // R5 surplus data bytes
        cond_start(); send_byte(8'hAA, a); send_byte(8'h08, a);
        send_byte(8'h5A, a); send_byte(8'h66, a2); send_byte(8'h77, a3); cond_stop();
        chk("R5 first byte ack", a, 1);
        chk("R5 second byte nack", a2, 0);
        chk("R5 third byte nack", a3, 0);
        chk("R5 stored first", regs[8], 8'h5A);
        chk("R5 neighbour untouched", regs[9], init_val(9));
        chk("R5 pointer", reg_addr, 7'h09);

        // R6 quick read at pointer
        quick_rd(d);
        chk("R6 quick read", d, init_val(9));
        chk("R6 pointer after nack", reg_addr, 7'h09);

        // R8 incremental read across the top
        cond_start(); send_byte(8'hAA, a); send_byte(8'h7E, a);
        cond_start(); send_byte(8'hAB, a);
        recv_byte(1'b1, d); chk("R8 byte 0x7E", d, init_val(8'h7E));
        recv_byte(1'b1, d); chk("R8 byte 0x7F", d, init_val(8'h7F));
        recv_byte(1'b1, d); chk("R8 wrap to 0x00", d, 8'h99);
        recv_byte(1'b0, d); chk("R8 byte 0x01", d, init_val(1));
        cond_stop();
        chk("R8 pointer no advance on nack", reg_addr, 7'h01);

        // R9 STOP in mid data byte
        cond_start(); send_byte(8'hAA, a); send_byte(8'h12, a);
        bit_w(1'b1); bit_w(1'b1); bit_w(1'b1);
        cond_stop();
        chk("R9 abort no write", regs[8'h12], init_val(8'h12));
        chk("R9 abort pointer kept", reg_addr, 7'h12);
        chk("R9 abort sda released", sda_oe, 0);
        quick_rd(d);
        chk("R9 engine usable after abort", d, init_val(8'h12));

        // R11 R12 SCL held low during an ACK
        cond_start();
        for (int i = 7; i >= 0; i--) bit_w(8'hAA >> i);
        sda_m = 1'b1; tick(HB);
        chk("R1 ack driven", sda_oe, 1);
        tick(TO - 60);
        chk("R11 no early release", sda_oe, 1);
        tick(70);
        chk("R11 released after timeout", sda_oe, 0);
        tick(ST + 20);
        chk("R12 sleep request", sleep_req, 1);
        scl_m = 1'b1; tick(5);
        chk("R12 sleep clears on free bus", sleep_req, 0);
        tick(HB);
        quick_rd(d);
        chk("R11 recovery read", d, init_val(8'h12));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule